// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the clock and data lines of a PS/2 keyboard and turns each device-to-host frame into a byte. Both lines are brought into the system clock domain and pass a short glitch filter. A bit is taken on each falling edge of the filtered keyboard clock. One frame holds a start bit, eight data bits with the least significant bit first, an odd parity bit and a stop bit, which makes eleven keyboard clock periods. The keyboard clock runs at about 10 to 15 kHz, so each bit lasts thousands of system cycles.

The receiver checks the start bit, the parity bit and the stop bit. A good frame produces the byte with a one-cycle strobe. A bad frame is dropped and reported on a one-cycle parity or framing error flag. A lost or extra keyboard clock edge would otherwise shift the alignment of every later frame. To prevent this, an idle watchdog empties any partial frame when no falling edge has arrived for a set time, about 100 microseconds by default. The receiver then waits for a fresh start bit.

Top module: `ps2_frame_rx`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `rx_valid`, `parity_err` and `frame_err` are 0 and `rx_data` is 0x00.
- R2: A frame with start bit 0, an odd-parity bit and stop bit 1 produces `rx_valid`, and `rx_data` holds the eight data bits. The first data bit after the start bit lands in bit 0 of `rx_data` and the last one lands in bit 7.
- R3: `rx_valid`, `parity_err` and `frame_err` each stay high for exactly one cycle per event.
- R4: If a 1 is sampled where a start bit is expected, `frame_err` pulses and no frame begins. The next correct frame is received intact.
- R5: Parity is odd across the eight data bits and the parity bit. When that count is even, `parity_err` pulses, `rx_valid` stays low and `rx_data` keeps its previous value.
- R6: A stop bit sampled as 0 pulses `frame_err`, keeps `rx_valid` low and leaves `rx_data` unchanged. If the parity is also wrong, `parity_err` pulses in the same cycle.
- R7: A frame that has begun is dropped without any flag when no falling edge arrives for `IDLE_TIMEOUT_US` microseconds. The next full frame is then received correctly.
- R8: A level on either line that lasts fewer than `FILTER_LEN` system cycles is ignored.
- R9: `rx_valid` is never high together with an error flag, and `rx_data` changes only in a cycle where `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ps2_clk_in | input | 1 | Keyboard clock line as received (idle high) |
| ps2_dat_in | input | 1 | Keyboard data line as received (idle high) |
| rx_data | output | 8 | Last byte received without error |
| rx_valid | output | 1 | One-cycle strobe for a new good byte |
| parity_err | output | 1 | One-cycle flag: frame dropped for bad parity |
| frame_err | output | 1 | One-cycle flag: frame dropped for a bad start or stop bit |

## Verification
The assertions assume that the keyboard clock stays at each level for at least two filtered samples, which is what lets a filtered edge be followed by a stable cycle. They also assume that the data line is steady around every falling clock edge. The stimulus keeps to this: it changes data only in the middle of the clock-high phase and holds each clock level for tens of cycles. The one deliberate exception is a two-cycle glitch, which is shorter than the filter length. The gap between edges inside a frame is kept well under the idle timeout, except where a frame is cut off on purpose to test the timeout.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int DATA_BITS = 8;
  localparam int IDX_W     = 4;
  localparam int PAR_IDX   = DATA_BITS + 1;
  localparam int STOP_IDX  = DATA_BITS + 2;

  typedef logic [IDX_W-1:0] bit_idx_t;
  typedef logic [DATA_BITS-1:0] byte_t;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int CNT_W = $clog2(FILTER_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   level_q, level_d;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end

  always_comb begin
    level_d = level_q;
    cnt_d   = '0;
    if (synced != level_q) begin
      if (cnt_q == CNT_W'(FILTER_LEN - 1)) begin
        level_d = synced;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign line_out = level_q;

  // R8: a filtered change is followed by at least one steady cycle
  assert_filter_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |=> $stable(level_q));
endmodule

// File: rtl/ps2_idle_watchdog.sv
module ps2_idle_watchdog #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic bit_edge,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_d, exp_q;

  always_comb begin
    cnt_d = '0;
    exp_d = 1'b0;
    if (busy && !bit_edge) begin
      if (cnt_q == CNT_W'(LIMIT - 1)) begin
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expire = exp_q;

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LIMIT));
  assert_expire_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/ps2_frame_assembler.sv
module ps2_frame_assembler
  import ps2_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clk_f,
  input  logic  dat_f,
  input  logic  abort,
  output logic  bit_edge,
  output logic  busy,
  output byte_t rx_data,
  output logic  rx_valid,
  output logic  parity_err,
  output logic  frame_err
);
  logic     clk_prev_q;
  bit_idx_t idx_q, idx_d;
  byte_t    shreg_q, shreg_d;
  byte_t    data_q, data_d;
  logic     par_q, par_d;
  logic     valid_q, valid_d;
  logic     perr_q, perr_d;
  logic     ferr_q, ferr_d;

  assign bit_edge = clk_prev_q & ~clk_f;
  assign busy     = (idx_q != '0);

  always_comb begin
    idx_d   = idx_q;
    shreg_d = shreg_q;
    data_d  = data_q;
    par_d   = par_q;
    valid_d = 1'b0;
    perr_d  = 1'b0;
    ferr_d  = 1'b0;
    if (bit_edge) begin
      if (idx_q == '0) begin
        if (!dat_f) begin
          idx_d = bit_idx_t'(1);
          par_d = 1'b0;
        end else begin
          ferr_d = 1'b1;
        end
      end else if (idx_q <= bit_idx_t'(DATA_BITS)) begin
        shreg_d = {dat_f, shreg_q[DATA_BITS-1:1]};
        par_d   = par_q ^ dat_f;
        idx_d   = idx_q + 1'b1;
      end else if (idx_q == bit_idx_t'(PAR_IDX)) begin
        par_d = par_q ^ dat_f;
        idx_d = idx_q + 1'b1;
      end else begin
        idx_d  = '0;
        perr_d = !par_q;
        ferr_d = !dat_f;
        if (par_q && dat_f) begin
          valid_d = 1'b1;
          data_d  = shreg_q;
        end
      end
    end else if (abort) begin
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b1;
      idx_q      <= '0;
      shreg_q    <= '0;
      data_q     <= '0;
      par_q      <= 1'b0;
      valid_q    <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
    end else begin
      clk_prev_q <= clk_f;
      idx_q      <= idx_d;
      shreg_q    <= shreg_d;
      data_q     <= data_d;
      par_q      <= par_d;
      valid_q    <= valid_d;
      perr_q     <= perr_d;
      ferr_q     <= ferr_d;
    end
  end

  assign rx_data    = data_q;
  assign rx_valid   = valid_q;
  assign parity_err = perr_q;
  assign frame_err  = ferr_q;

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err || frame_err) |=> !(parity_err || frame_err));
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(parity_err || frame_err));
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));
  assert_bad_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_edge && !busy && dat_f) |=> (frame_err && !busy));
  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !bit_edge) |=> !busy);
  assert_index_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= bit_idx_t'(STOP_IDX));
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx #(
  parameter int CLK_FREQ_HZ     = 50_000_000,
  parameter int IDLE_TIMEOUT_US = 100,
  parameter int SYNC_STAGES     = 2,
  parameter int FILTER_LEN      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       parity_err,
  output logic       frame_err
);
  localparam int TIMEOUT_CYCLES = (CLK_FREQ_HZ / 1_000_000) * IDLE_TIMEOUT_US;
  localparam int LINES = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] filt_lines;
  logic             bit_edge, busy, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_lines = {ps2_dat_in, ps2_clk_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    ps2_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILTER_LEN (FILTER_LEN)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .line_in (raw_lines[g]),
      .line_out(filt_lines[g])
    );
  end

  ps2_idle_watchdog #(
    .LIMIT(TIMEOUT_CYCLES)
  ) u_wdog (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .busy    (busy),
    .bit_edge(bit_edge),
    .expire  (expire)
  );

  ps2_frame_assembler u_asm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clk_f     (filt_lines[0]),
    .dat_f     (filt_lines[1]),
    .abort     (expire),
    .bit_edge  (bit_edge),
    .busy      (busy),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .parity_err(parity_err),
    .frame_err (frame_err)
  );

  // R1: outputs quiet while the internal reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int_n |-> !(rx_valid || parity_err || frame_err));
endmodule

// File: tb/ps2_frame_rx_test.sv
module ps2_frame_rx_test;
  localparam int HALF = 40;

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] data;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ps2_clk_in = 1'b1;
  logic       ps2_dat_in = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, parity_err, frame_err;

  int checks = 0;
  int errors = 0;
  exp_item_t exp_q[$];
  logic [7:0] last_good = 8'h00;
  logic prev_event = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ps2_frame_rx #(
    .CLK_FREQ_HZ    (50_000_000),
    .IDLE_TIMEOUT_US(4),
    .SYNC_STAGES    (2),
    .FILTER_LEN     (4)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ps2_clk_in(ps2_clk_in),
    .ps2_dat_in(ps2_dat_in),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .parity_err(parity_err),
    .frame_err (frame_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    repeat (HALF / 2) @(posedge clk);
    ps2_dat_in = b;
    repeat (HALF / 2) @(posedge clk);
    ps2_clk_in = 1'b0;
    repeat (HALF) @(posedge clk);
    ps2_clk_in = 1'b1;
  endtask

  // kind: 0 good, 1 parity error, 2 framing error, 3 both
  task automatic send_frame(input logic [7:0] b, input bit bad_par, input logic stop,
                            input logic [1:0] kind);
    logic p;
    exp_item_t e;
    p = ~^b;
    if (bad_par) p = ~p;
    e.kind = kind;
    e.data = b;
    exp_q.push_back(e);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(p);
    send_bit(stop);
    ps2_dat_in = 1'b1;
    repeat (3 * HALF) @(posedge clk);
  endtask

  // monitor: pops one expected item per reported event
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic ev;
      ev = rx_valid | parity_err | frame_err;
      if (prev_event)
        check(!ev, "R3 flag longer than one cycle", int'(ev), 0);
      if (ev) begin
        logic [1:0] got;
        got = rx_valid ? 2'd0 : {frame_err, parity_err};
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected event", int'(got), 0);
        end else begin
          exp_item_t e;
          e = exp_q.pop_front();
          check(got == e.kind, "R2/R4/R5/R6 event kind", int'(got), int'(e.kind));
          if (e.kind == 2'd0) begin
            check(rx_data == e.data, "R2 byte value", int'(rx_data), int'(e.data));
            last_good = e.data;
          end else begin
            check(rx_data == last_good, "R5/R6 data kept after error", int'(rx_data),
                  int'(last_good));
          end
        end
      end
      prev_event = ev;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!rx_valid && !parity_err && !frame_err, "R1 flags in reset",
          int'({rx_valid, parity_err, frame_err}), 0);
    check(rx_data == 8'h00, "R1 data in reset", int'(rx_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rx_valid && !parity_err && !frame_err, "R1 flags after release",
          int'({rx_valid, parity_err, frame_err}), 0);
    repeat (20) @(posedge clk);

    // R2: several byte patterns, LSB first
    send_frame(8'hA5, 1'b0, 1'b1, 2'd0);
    send_frame(8'h01, 1'b0, 1'b1, 2'd0);
    send_frame(8'h80, 1'b0, 1'b1, 2'd0);
    send_frame(8'h00, 1'b0, 1'b1, 2'd0);
    send_frame(8'hFF, 1'b0, 1'b1, 2'd0);

    // R5: bad parity
    send_frame(8'h3C, 1'b1, 1'b1, 2'd1);
    // R6: bad stop, then bad stop and bad parity together
    send_frame(8'h5A, 1'b0, 1'b0, 2'd2);
    send_frame(8'h77, 1'b1, 1'b0, 2'd3);

    // R4: a 1 where a start bit is expected
    begin
      exp_item_t e;
      e.kind = 2'd2;
      e.data = 8'h00;
      exp_q.push_back(e);
    end
    send_bit(1'b1);
    repeat (3 * HALF) @(posedge clk);
    send_frame(8'h6B, 1'b0, 1'b1, 2'd0);

    // R7: partial frame abandoned after idle time, no flag
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    ps2_dat_in = 1'b1;
    repeat (400) @(posedge clk);
    check(exp_q.size() == 0, "R7 no event from partial frame", exp_q.size(), 0);
    send_frame(8'hC3, 1'b0, 1'b1, 2'd0);

    // R8: short glitch on the clock line with data low
    ps2_dat_in = 1'b0;
    repeat (10) @(posedge clk);
    ps2_clk_in = 1'b0;
    repeat (2) @(posedge clk);
    ps2_clk_in = 1'b1;
    repeat (20) @(posedge clk);
    ps2_dat_in = 1'b1;
    send_frame(8'h96, 1'b0, 1'b1, 2'd0);

    // R8: short glitch on the data line while the clock falls is absent
    ps2_dat_in = 1'b0;
    repeat (2) @(posedge clk);
    ps2_dat_in = 1'b1;
    send_frame(8'h2D, 1'b0, 1'b1, 2'd0);

    repeat (20) @(posedge clk);
    check(exp_q.size() == 0, "R2 all expected events seen", exp_q.size(), 0);
    check(rx_data == 8'h2D, "R9 final data held", int'(rx_data), 8'h2D);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule